// File: doc/BRIEF.md
# Dual-Style Processor Bus Register Slave

This block is a register-access slave for an 8-bit processor bus. It runs from its own reference clock. It accepts two strobe conventions:

- **Read/write-strobe style:** separate active-low read and write strobes, with a ready output.
- **Data-strobe style:** one active-low data strobe, a read/write level and an active-low acknowledge output.

Either style can use a separate 5-bit address bus or share the 8-bit data bus for address and data. Two static mode pins choose one of the four resulting modes.

All bus control pins pass through two-flop synchronizers into the reference-clock domain. A state machine holds the handshake until a fixed count of wait states has elapsed, so the handshake does not depend on how fast the processor bus runs.

The machine has five states:

- **IDLE:** waits for an access.
- **WAIT:** counts wait states; the write is applied when it leaves.
- **HOLD:** the handshake shows completion until the strobe is released.
- **DONE:** one-cycle ready-low marker after a normal write in read/write-strobe style.
- **RSEQ:** reset-register sequence.

The transitions are:

- IDLE→WAIT on a synchronized access.
- WAIT→HOLD when the count expires.
- WAIT→RSEQ instead when a reset-register write is made in read/write-strobe, separate-address mode.
- HOLD→DONE on release after a write in read/write-strobe style.
- HOLD→IDLE on any other release.
- DONE→IDLE after one cycle.
- RSEQ→IDLE once its hold-off count has expired and the strobe is released.

The register bank has 18 registers at addresses 0x00 to 0x11:

- **0x00:** sticky alarm status, cleared by writing 1.
- **0x01:** interrupt enable.
- **0x0A:** soft-reset register; a write clears every register.
- **All other addresses in the range:** plain read/write configuration.

The active-low interrupt output follows the enabled status bits. The data bus is presented as separate input, output and output-enable ports, so that the pad ring builds the tri-state buffer.

Top module: `pbus_slave`

## Requirements
- R1: `mux_mode`=0 selects a separate address bus (`addr`). `mux_mode`=1 selects a shared bus, where the address is the low 5 bits of `d_in`. `style_rw`=1 selects read/write strobes (`rd_n`, `wr_n`) with a ready output. `style_rw`=0 selects a data strobe (`ds_n`) with level `rw` (1 = read, 0 = write) and an acknowledge output. All four combinations give the same register behaviour.
- R2: With no other access in progress, the handshake output shows completion on the 5th rising reference-clock edge after the strobe is asserted. That count is 2 synchronizer stages, plus 1 edge for IDLE→WAIT, plus 2 wait states.
- R3: In read/write-strobe style, `hshk` is ready. It is high when idle, low during the wait states, and high at completion. It stays high until the strobe is released.
- R4: In data-strobe style, `hshk` is an active-low acknowledge. It is high when idle and during wait states. It goes low at completion and returns high on the 3rd rising edge after the data strobe is released.
- R5: In read/write-strobe style, after a normal write's strobe is released, `hshk` is low for exactly one cycle (the 3rd edge after release) and then high again. A read shows no such low cycle.
- R6: A write to address 0x0A clears every register to 0x00, and 0x0A always reads 0x00. In read/write-strobe style with a separate address bus, this write gives no low cycle on `hshk` after completion. `hshk` stays high through the following hold-off sequence.
- R7: In shared-bus modes, the address is captured on the falling edge of `alat`. In data-strobe separate-address mode, it is captured on the falling edge of `ds_n`. Changing `addr` afterwards has no effect. In read/write-strobe separate-address mode, `addr` is used while the strobe is active.
- R8: Addresses 0x01 to 0x11, except 0x0A, read back the last value written to them.
- R9: Addresses 0x12 to 0x1F read 0x00, and writes to them change no register.
- R10: `d_oe` is 1 only while `cs_n` is low and a read is active. A read is active when `rd_n` is low in read/write-strobe style, or when `ds_n` is low with `rw`=1 in data-strobe style.
- R11: Status bit i at 0x00 is set by `alarm[i]` being high at a clock edge and stays set. Writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged.
- R12: `irq_n` is low exactly when some status bit is 1 and the matching bit of the enable register (0x01) is also 1.
- R13: While `rst_n` is low, `hshk`=1, `irq_n`=1 and `d_oe`=0. After reset, all registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for synchronizers, wait states and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | 1 = shared address/data bus, 0 = separate address bus |
| style_rw | input | 1 | 1 = read/write strobes with ready, 0 = data strobe with acknowledge |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe (read/write-strobe style) |
| wr_n | input | 1 | Active-low write strobe (read/write-strobe style) |
| ds_n | input | 1 | Active-low data strobe (data-strobe style) |
| rw | input | 1 | Direction level in data-strobe style: 1 read, 0 write |
| alat | input | 1 | Address latch strobe, falling edge captures address on the shared bus |
| addr | input | 5 | Separate address bus |
| d_in | input | 8 | Data bus as seen by the block (address too in shared modes) |
| d_out | output | 8 | Read data toward the bus |
| d_oe | output | 1 | Drive enable for d_out |
| hshk | output | 1 | Ready (read/write-strobe style) or active-low acknowledge (data-strobe style) |
| alarm | input | 8 | Alarm inputs, synchronous to clk |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to reach from the ports is the reset-register write in read/write-strobe, separate-address mode. Here the bench must see that no low cycle follows completion, and that every register is cleared. The bench fills all 32 addresses in each of the four modes, then writes 0x0A and watches `hshk` for the whole hold-off window before sweeping the reads again.

In data-strobe separate-address mode, `addr` is scrambled right after `ds_n` falls. In shared modes, `addr` carries junk throughout. A read-back that still matches therefore proves that the address came from the latch.

Sticky-status clearing is reached by pulsing single alarm bits between accesses. One enabled bit and one masked bit are set, then cleared one at a time.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int DAT_W = 8;
    localparam int ADR_W = 5;

    // Addresses whose behaviour differs from plain storage
    localparam logic [ADR_W-1:0] ADR_STAT = 5'h00;
    localparam logic [ADR_W-1:0] ADR_IEN  = 5'h01;
    localparam logic [ADR_W-1:0] ADR_SRST = 5'h0A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HOLD,
        ST_DONE,
        ST_RSEQ
    } bus_st_e;

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/pbus_adrlat.sv
module pbus_adrlat #(
    parameter int AW = 5
) (
    input  logic          rst_n,
    input  logic          mux_mode,
    input  logic          style_rw,
    input  logic          alat,
    input  logic          ds_n,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] bus_adr,
    output logic [AW-1:0] sel_adr
);

    logic [AW-1:0] ale_q;
    logic [AW-1:0] dsa_q;

    // Shared-bus modes: address taken when the latch strobe falls
    always_ff @(negedge alat or negedge rst_n) begin
        if (!rst_n) ale_q <= '0;
        else        ale_q <= bus_adr;
    end

    // Data-strobe, separate-address mode: address taken when the strobe falls
    always_ff @(negedge ds_n or negedge rst_n) begin
        if (!rst_n) dsa_q <= '0;
        else        dsa_q <= addr;
    end

    always_comb begin
        if (mux_mode)      sel_adr = ale_q;
        else if (style_rw) sel_adr = addr;
        else               sel_adr = dsa_q;
    end

endmodule

// File: rtl/pbus_regbank.sv
module pbus_regbank import pbus_pkg::*; #(
    parameter int NUM_REGS = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             soft_rst,
    input  logic [ADR_W-1:0] adr,
    input  logic [DAT_W-1:0] wdata,
    input  logic [DAT_W-1:0] alarm,
    output logic [DAT_W-1:0] rdata,
    output logic             irq_n
);

    logic [DAT_W-1:0] rd_arr [NUM_REGS];
    logic [DAT_W-1:0] stat_q;
    logic [DAT_W-1:0] ien_q;
    logic             wr_stat;
    logic             wr_ien;

    assign wr_stat = wr_en && (adr == ADR_STAT);
    assign wr_ien  = wr_en && (adr == ADR_IEN);

    // Sticky alarm status, write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stat_q <= '0;
        else if (soft_rst) stat_q <= '0;
        else if (wr_stat)  stat_q <= (stat_q & ~wdata) | alarm;
        else               stat_q <= stat_q | alarm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ien_q <= '0;
        else if (soft_rst) ien_q <= '0;
        else if (wr_ien)   ien_q <= wdata;
    end

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            if (ADR_W'(i) == ADR_STAT) begin : g_stat
                assign rd_arr[i] = stat_q;
            end else if (ADR_W'(i) == ADR_IEN) begin : g_ien
                assign rd_arr[i] = ien_q;
            end else if (ADR_W'(i) == ADR_SRST) begin : g_srst
                assign rd_arr[i] = '0;
            end else begin : g_plain
                logic [DAT_W-1:0] cfg_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)                              cfg_q <= '0;
                    else if (soft_rst)                       cfg_q <= '0;
                    else if (wr_en && (adr == ADR_W'(i)))    cfg_q <= wdata;
                end
                assign rd_arr[i] = cfg_q;
            end
        end
    endgenerate

    // Unimplemented addresses fall through to zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (adr == ADR_W'(i)) rdata = rd_arr[i];
        end
    end

    assign irq_n = ~|(stat_q & ien_q);

    // A status bit may only drop through a status write or a soft reset
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stat_q) & ~stat_q)) |-> $past(wr_stat || soft_rst));

    // Soft reset leaves enables and status cleared
    p_srst_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (stat_q == '0 && ien_q == '0));

endmodule

// File: rtl/pbus_slave.sv
module pbus_slave import pbus_pkg::*; #(
    parameter int NUM_REGS    = 18,
    parameter int WAIT_CYC    = 2,
    parameter int RST_CYC     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mux_mode,
    input  logic             style_rw,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             ds_n,
    input  logic             rw,
    input  logic             alat,
    input  logic [ADR_W-1:0] addr,
    input  logic [DAT_W-1:0] d_in,
    output logic [DAT_W-1:0] d_out,
    output logic             d_oe,
    output logic             hshk,
    input  logic [DAT_W-1:0] alarm,
    output logic             irq_n
);

    localparam int CMAX = (WAIT_CYC > RST_CYC) ? WAIT_CYC : RST_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int NSYN = 5;

    // ---------------- synchronized bus controls ----------------
    logic [NSYN-1:0] ctl_raw;
    logic [NSYN-1:0] ctl_s;
    logic cs_a, rd_a, wr_a, ds_a, rw_s;
    logic acc_s, is_wr;

    assign ctl_raw = {cs_n, rd_n, wr_n, ds_n, rw};

    pbus_sync #(
        .W       (NSYN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NSYN{1'b1}})
    ) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    assign cs_a  = !ctl_s[4];
    assign rd_a  = !ctl_s[3];
    assign wr_a  = !ctl_s[2];
    assign ds_a  = !ctl_s[1];
    assign rw_s  =  ctl_s[0];
    assign acc_s = cs_a && (style_rw ? (rd_a || wr_a) : ds_a);
    assign is_wr = style_rw ? wr_a : (ds_a && !rw_s);

    // ---------------- address selection ----------------
    logic [ADR_W-1:0] sel_adr;

    pbus_adrlat #(.AW(ADR_W)) u_adrlat (
        .rst_n    (rst_n),
        .mux_mode (mux_mode),
        .style_rw (style_rw),
        .alat     (alat),
        .ds_n     (ds_n),
        .addr     (addr),
        .bus_adr  (d_in[ADR_W-1:0]),
        .sel_adr  (sel_adr)
    );

    // ---------------- wait-state machine ----------------
    bus_st_e       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wr_q, wr_d;
    logic          last_wait, last_rst;
    logic          wr_fire, soft_rst, rst_special;

    assign last_wait   = (cnt_q == CW'(WAIT_CYC - 1));
    assign last_rst    = (cnt_q == CW'(RST_CYC - 1));
    assign wr_fire     = (st_q == ST_WAIT) && last_wait && is_wr;
    assign soft_rst    = wr_fire && (sel_adr == ADR_SRST);
    assign rst_special = soft_rst && style_rw && !mux_mode;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        wr_d  = wr_q;
        unique case (st_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (acc_s) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (last_wait) begin
                    cnt_d = '0;
                    wr_d  = is_wr;
                    st_d  = rst_special ? ST_RSEQ : ST_HOLD;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_HOLD: begin
                if (!acc_s) st_d = (style_rw && wr_q) ? ST_DONE : ST_IDLE;
            end
            ST_DONE: begin
                st_d = ST_IDLE;
            end
            ST_RSEQ: begin
                if (!last_rst)   cnt_d = cnt_q + CW'(1);
                else if (!acc_s) st_d  = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            wr_q  <= wr_d;
        end
    end

    // Handshake level per state: ready is high-true, acknowledge low-true
    always_comb begin
        unique case (st_q)
            ST_IDLE: hshk = 1'b1;
            ST_WAIT: hshk = !style_rw;
            ST_HOLD: hshk = style_rw;
            ST_DONE: hshk = !style_rw;
            ST_RSEQ: hshk = 1'b1;
            default: hshk = 1'b1;
        endcase
    end

    // ---------------- register bank and data bus ----------------
    logic [DAT_W-1:0] rdata;

    pbus_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_fire),
        .soft_rst (soft_rst),
        .adr      (sel_adr),
        .wdata    (d_in),
        .alarm    (alarm),
        .rdata    (rdata),
        .irq_n    (irq_n)
    );

    assign d_out = rdata;
    assign d_oe  = !cs_n && (style_rw ? !rd_n : (!ds_n && rw));

    // ---------------- assertions ----------------
    p_mode_static_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({mux_mode, style_rw}));

    p_idle_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> (st_q == ST_IDLE || st_q == ST_WAIT));

    p_hold_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && acc_s) |=> (st_q == ST_HOLD));

    p_done_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) |=> (st_q == ST_IDLE));

    p_rseq_no_dip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RSEQ) |=> (st_q == ST_RSEQ || st_q == ST_IDLE));

    p_wait_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |=> (st_q == ST_WAIT || st_q == ST_HOLD || st_q == ST_RSEQ));

endmodule

// File: tb/pbus_slave_tb_top.sv
module pbus_slave_tb_top;

    localparam int LAT = 2 + 1 + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mux = 1'b0;
    logic       sty = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       ds_n = 1'b1;
    logic       rw = 1'b1;
    logic       alat = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] tb_drv = '0;
    logic [7:0] alarm = '0;
    logic [7:0] d_in, d_out;
    logic       d_oe, hshk, irq_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign d_in = d_oe ? d_out : tb_drv;

    pbus_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mux_mode (mux),
        .style_rw (sty),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .ds_n     (ds_n),
        .rw       (rw),
        .alat     (alat),
        .addr     (addr),
        .d_in     (d_in),
        .d_out    (d_out),
        .d_oe     (d_oe),
        .hshk     (hshk),
        .alarm    (alarm),
        .irq_n    (irq_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One bus access in the current mode; waits for completion and release
    task automatic access(input bit is_wr, input logic [4:0] a, input logic [7:0] wd,
                          output logic [7:0] rd);
        int n;
        bit seen;
        bit done;
        bit special;
        special = is_wr && (a == 5'h0A) && sty && !mux;
        rd = '0;
        @(negedge clk);
        if (mux) begin
            tb_drv = {3'b000, a};
            addr   = ~a;
            alat   = 1'b1;
            @(negedge clk);
            alat   = 1'b0;
            @(negedge clk);
            tb_drv = is_wr ? wd : 8'h00;
        end else begin
            addr   = a;
            tb_drv = wd;
            @(negedge clk);
        end
        cs_n = 1'b0;
        if (sty) begin
            if (is_wr) wr_n = 1'b0;
            else       rd_n = 1'b0;
        end else begin
            rw   = !is_wr;
            ds_n = 1'b0;
        end
        n = 0; seen = 0; done = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (!sty && !mux && n == 1) addr = ~a;   // R7: latched address must survive
            if (sty) begin
                if (!hshk) seen = 1;
                done = seen && hshk;
            end else begin
                done = !hshk;
            end
        end
        chk(n == LAT, "R2 handshake latency", n, LAT);
        if (sty) chk(seen, "R3 ready low during wait", seen, 1);
        if (is_wr) chk(d_oe == 1'b0, "R10 no drive on write", d_oe, 0);
        else begin
            chk(d_oe == 1'b1, "R10 drive on read", d_oe, 1);
            rd = d_out;
        end
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ds_n = 1'b1; rw = 1'b1; alat = 1'b1;
        @(negedge clk);
        chk(d_oe == 1'b0, "R10 released", d_oe, 0);
        if (sty && special) begin
            for (int k = 0; k < 14; k++) begin
                chk(hshk == 1'b1, "R6 ready stays high", hshk, 1);
                @(negedge clk);
            end
        end else if (sty) begin
            @(negedge clk);
            chk(hshk == 1'b1, "R3 ready held until release seen", hshk, 1);
            @(negedge clk);
            chk(hshk == !is_wr, "R5 write completion dip", hshk, !is_wr);
            @(negedge clk);
            chk(hshk == 1'b1, "R5 ready back high", hshk, 1);
        end else begin
            @(negedge clk);
            chk(hshk == 1'b0, "R4 ack held", hshk, 0);
            @(negedge clk);
            chk(hshk == 1'b1, "R4 ack released", hshk, 1);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_alarm(input logic [7:0] v);
        @(negedge clk);
        alarm = v;
        @(negedge clk);
        alarm = '0;
    endtask

    function automatic logic [7:0] pat(input int a, input int m);
        return 8'((a * 37 + m * 11 + 5) & 255);
    endfunction

    initial begin
        logic [7:0] rv;
        logic [7:0] ev;
        for (int m = 0; m < 4; m++) begin
            rst_n = 1'b0;
            mux = m[1];
            sty = m[0];
            repeat (4) @(negedge clk);
            chk(hshk == 1'b1, "R13 hshk in reset", hshk, 1);
            chk(irq_n == 1'b1, "R13 irq_n in reset", irq_n, 1);
            chk(d_oe == 1'b0, "R13 d_oe in reset", d_oe, 0);
            rst_n = 1'b1;
            repeat (2) @(negedge clk);
            access(0, 5'h02, 8'h00, rv);
            chk(rv == 8'h00, "R13 reg after reset", rv, 0);
            access(0, 5'h11, 8'h00, rv);
            chk(rv == 8'h00, "R13 reg after reset", rv, 0);

            // Fill every address, skipping status and soft reset
            for (int a = 0; a < 32; a++) begin
                if (a != 0 && a != 10) access(1, 5'(a), pat(a, m), rv);
            end
            for (int a = 0; a < 32; a++) begin
                access(0, 5'(a), 8'h00, rv);
                ev = (a < 18 && a != 0 && a != 10) ? pat(a, m) : 8'h00;
                if (a >= 18) chk(rv == ev, "R9 unimplemented reads zero", rv, ev);
                else         chk(rv == ev, "R1 R7 R8 readback", rv, ev);
            end
            chk(irq_n == 1'b1, "R12 no status no irq", irq_n, 1);

            // Soft reset register
            access(1, 5'h0A, 8'hFF, rv);
            for (int a = 0; a < 32; a++) begin
                access(0, 5'(a), 8'h00, rv);
                chk(rv == 8'h00, "R6 cleared by soft reset", rv, 0);
            end

            // Sticky status and interrupt
            access(1, 5'h01, 8'h05, rv);
            pulse_alarm(8'h04);
            chk(irq_n == 1'b0, "R12 enabled alarm raises irq", irq_n, 0);
            access(0, 5'h00, 8'h00, rv);
            chk(rv == 8'h04, "R11 status sticky", rv, 8'h04);
            pulse_alarm(8'h02);
            access(0, 5'h00, 8'h00, rv);
            chk(rv == 8'h06, "R11 status accumulates", rv, 8'h06);
            chk(irq_n == 1'b0, "R12 irq still low", irq_n, 0);
            access(1, 5'h00, 8'h04, rv);
            access(0, 5'h00, 8'h00, rv);
            chk(rv == 8'h02, "R11 write one clears", rv, 8'h02);
            chk(irq_n == 1'b1, "R12 masked bit no irq", irq_n, 1);
            access(1, 5'h00, 8'h00, rv);
            access(0, 5'h00, 8'h00, rv);
            chk(rv == 8'h02, "R11 write zero no effect", rv, 8'h02);
            access(1, 5'h00, 8'h02, rv);
            access(0, 5'h00, 8'h00, rv);
            chk(rv == 8'h00, "R11 cleared", rv, 8'h00);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule